// File: doc/BRIEF.md
# Prioritized Chip Select Unit

This block turns the address of each bus cycle into active-low select lines for four programmable address regions: an upper memory area, a lower memory area, a mid-range memory area and a peripheral area in I/O space. For every cycle it also gives the wait-state count and an external-ready-enable flag taken from the region that wins. When regions overlap, all of the regions hit assert their selects together. The wait and ready settings come from the region that ranks highest: mid-range, then upper, then lower, then peripheral.

The unit also holds the relocation register for an internal peripheral control window of fixed size. This window can sit anywhere in I/O space or in memory space. A cycle that falls in the window gets no select at all, runs with zero waits and ignores external ready. The relocation register lives inside the unit, and the decode result is taken before any select is driven. Because of this, such a cycle never shows even a brief pulse on a select. An interrupt-acknowledge cycle is never taken as a window hit, even when the window sits at I/O address 0, and external ready is honoured on it.

The controller has two states. `ST_IDLE` waits for `cyc_start`. On the **start** transition (ST_IDLE to ST_BUSY), the decode is latched and the selects drive from the next clock on. `ST_BUSY` counts the wait states down. On the **finish** transition (ST_BUSY to ST_IDLE), taken in the clock where `cyc_done` is high, the selects release at that edge. In every other case each state holds.

Top module: `csel_unit`

## Requirements
- R1: After reset every select is high and the unit is idle. Only the upper region is enabled: it covers the top 1024 addresses of memory space, with 3 waits and ready enabled. The window is at I/O base 0x0FF00.
- R2: The selects of a cycle go low in the clock after the one in which `cyc_start` is sampled high. They stay constant until the clock in which `cyc_done` is high, and they are high again from the next clock.
- R3: A region is hit when it is enabled, its space matches, and base <= address < base + size. Upper, lower and mid regions decode memory cycles (`is_mem`=1). The peripheral region decodes I/O cycles. `sel_n` bit 0 is upper, bit 1 lower, bit 2 mid and bit 3 peripheral.
- R4: Every region that is hit asserts its select. `wait_cnt` and `rdy_use` come from the highest-ranked region hit, in the order mid, upper, lower, peripheral. A cycle that hits no region has 0 waits and ready ignored.
- R5: With ready disabled, a cycle lasts exactly W+1 clocks in ST_BUSY, where W (0 to 3) is the full programmed wait count.
- R6: With ready enabled, the cycle ends in the first ST_BUSY clock in which the wait count has run out and `rdy` is high.
- R7: A cycle inside the window drives no select in any clock. It shows `pcb_hit`=1 and `rdy_use`=0, has 0 waits, and lasts one clock whatever `rdy` does.
- R8: Writing register index 4 moves the window. Bits [19:0] are the base and bit 20 is the space (1 is memory, 0 is I/O). The window covers 256 addresses from the base, in that space only.
- R9: An interrupt-acknowledge cycle (`inta`=1) never hits the window and drives no select. It has 0 waits and `rdy_use`=1, so it ends in the first ST_BUSY clock in which `rdy` is high.
- R10: A `cyc_start` that arrives while the unit is in ST_BUSY is ignored. It changes neither the selects nor the length of the cycle.
- R11: Register indices 0 to 3 write the upper, lower, mid and peripheral regions. The field layout is: bits [19:0] base, [39:20] size, [41:40] waits, [42] ready enable, [43] region enable. A cycle already in progress keeps its latched settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register index (0-3 regions, 4 relocation) |
| cfg_wdata | input | 44 | Configuration write data |
| cyc_start | input | 1 | Bus cycle start strobe |
| addr | input | 20 | Cycle address |
| is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| inta | input | 1 | Interrupt-acknowledge cycle flag |
| rdy | input | 1 | External ready |
| sel_n | output | 4 | Active-low selects (upper, lower, mid, peripheral) |
| wait_cnt | output | 2 | Wait count of the current cycle |
| rdy_use | output | 1 | External ready is honoured in the current cycle |
| pcb_hit | output | 1 | The current cycle hits the peripheral control window |
| cyc_done | output | 1 | The current cycle ends this clock |

## Verification
The assertions assume that `addr`, `is_mem` and `inta` are stable in the clock where `cyc_start` is sampled. They also assume that `rdy` is a clean level for each clock and that configuration writes never overlap a cycle start in a way that matters. The bench changes every input only on the falling clock edge. It issues each configuration write while the unit is idle, and it raises `cyc_start` for one clock per cycle, except for the deliberate second strobe in the middle of a busy cycle. A behavioural model that holds its own copy of the programmed regions predicts every output on every clock.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int NUM_RG   = 4;
    localparam int RG_UPPER = 0;
    localparam int RG_LOWER = 1;
    localparam int RG_MID   = 2;
    localparam int RG_PERI  = 3;
    localparam int RELOC_IDX = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } csel_state_e;

    typedef struct packed {
        logic       en;
        logic       rdy_en;
        logic [1:0] waits;
    } region_ctl_t;
endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
    import csel_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int UMEM_RST_SIZE = 1024,
    parameter int PCB_RST_BASE  = 'h0FF00
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [2:0]                       cfg_addr,
    input  logic [2*ADDR_W+3:0]              cfg_wdata,
    output logic [NUM_RG-1:0][ADDR_W-1:0]    rg_base,
    output logic [NUM_RG-1:0][ADDR_W-1:0]    rg_size,
    output region_ctl_t [NUM_RG-1:0]         rg_ctl,
    output logic [ADDR_W-1:0]                pcb_base,
    output logic                             pcb_in_mem
);
    localparam logic [ADDR_W-1:0] UP_BASE = ~ADDR_W'(UMEM_RST_SIZE - 1);
    localparam logic [ADDR_W-1:0] UP_SIZE = ADDR_W'(UMEM_RST_SIZE);

    for (genvar g = 0; g < NUM_RG; g++) begin : g_region
        localparam bit IS_UP = (g == RG_UPPER);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rg_base[g] <= IS_UP ? UP_BASE : '0;
                rg_size[g] <= IS_UP ? UP_SIZE : '0;
                rg_ctl[g]  <= IS_UP ? region_ctl_t'{en: 1'b1, rdy_en: 1'b1, waits: 2'd3}
                                    : region_ctl_t'{en: 1'b0, rdy_en: 1'b0, waits: 2'd0};
            end else if (cfg_we && cfg_addr == 3'(g)) begin
                rg_base[g] <= cfg_wdata[ADDR_W-1:0];
                rg_size[g] <= cfg_wdata[2*ADDR_W-1:ADDR_W];
                rg_ctl[g]  <= cfg_wdata[2*ADDR_W+3:2*ADDR_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcb_base   <= ADDR_W'(PCB_RST_BASE);
            pcb_in_mem <= 1'b0;
        end else if (cfg_we && cfg_addr == 3'(RELOC_IDX)) begin
            pcb_base   <= cfg_wdata[ADDR_W-1:0];
            pcb_in_mem <= cfg_wdata[ADDR_W];
        end
    end
endmodule

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int PCB_SIZE = 256
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             is_mem,
    input  logic                             inta,
    input  logic [NUM_RG-1:0][ADDR_W-1:0]    rg_base,
    input  logic [NUM_RG-1:0][ADDR_W-1:0]    rg_size,
    input  region_ctl_t [NUM_RG-1:0]         rg_ctl,
    input  logic [ADDR_W-1:0]                pcb_base,
    input  logic                             pcb_in_mem,
    output logic [NUM_RG-1:0]                hit_vec,
    output logic                             pcb_match,
    output logic [1:0]                       win_waits,
    output logic                             win_rdy
);
    localparam logic [ADDR_W:0] PCB_SPAN = (ADDR_W+1)'(PCB_SIZE);

    logic [ADDR_W:0] addr_x;
    assign addr_x = {1'b0, addr};

    for (genvar g = 0; g < NUM_RG; g++) begin : g_match
        localparam bit IS_IO = (g == RG_PERI);
        logic space_ok;
        logic [ADDR_W:0] lim;
        assign space_ok   = IS_IO ? !is_mem : is_mem;
        assign lim        = {1'b0, rg_base[g]} + {1'b0, rg_size[g]};
        assign hit_vec[g] = rg_ctl[g].en && space_ok &&
                            (addr_x >= {1'b0, rg_base[g]}) && (addr_x < lim);
    end

    logic [ADDR_W:0] pcb_lim;
    assign pcb_lim   = {1'b0, pcb_base} + PCB_SPAN;
    assign pcb_match = !inta && (is_mem == pcb_in_mem) &&
                       (addr_x >= {1'b0, pcb_base}) && (addr_x < pcb_lim);

    // fixed ranking: later assignments override earlier ones
    always_comb begin
        win_waits = 2'd0;
        win_rdy   = 1'b0;
        if (hit_vec[RG_PERI])  begin win_waits = rg_ctl[RG_PERI].waits;  win_rdy = rg_ctl[RG_PERI].rdy_en;  end
        if (hit_vec[RG_LOWER]) begin win_waits = rg_ctl[RG_LOWER].waits; win_rdy = rg_ctl[RG_LOWER].rdy_en; end
        if (hit_vec[RG_UPPER]) begin win_waits = rg_ctl[RG_UPPER].waits; win_rdy = rg_ctl[RG_UPPER].rdy_en; end
        if (hit_vec[RG_MID])   begin win_waits = rg_ctl[RG_MID].waits;   win_rdy = rg_ctl[RG_MID].rdy_en;   end
    end
endmodule

// File: rtl/csel_cycle_fsm.sv
module csel_cycle_fsm
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              inta,
    input  logic              rdy,
    input  logic [NUM_RG-1:0] hit_vec,
    input  logic              pcb_match,
    input  logic [1:0]        win_waits,
    input  logic              win_rdy,
    output logic [NUM_RG-1:0] sel_n,
    output logic [1:0]        wait_cnt,
    output logic              rdy_use,
    output logic              pcb_hit,
    output logic              cyc_done
);
    csel_state_e       state, nxt;
    logic [NUM_RG-1:0] sel_q;
    logic [1:0]        waits_q, cnt_q;
    logic              ru_q, pcb_q, done;

    assign done = (state == ST_BUSY) && (cnt_q == 2'd0) && (!ru_q || rdy);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (cyc_start) nxt = ST_BUSY;
            ST_BUSY: if (done)      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            waits_q <= '0;
            cnt_q   <= '0;
            ru_q    <= 1'b0;
            pcb_q   <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (cyc_start) begin
                if (pcb_match || inta) begin
                    sel_q   <= '0;
                    waits_q <= 2'd0;
                    cnt_q   <= 2'd0;
                    ru_q    <= inta;
                end else begin
                    sel_q   <= hit_vec;
                    waits_q <= win_waits;
                    cnt_q   <= win_waits;
                    ru_q    <= win_rdy;
                end
                pcb_q <= pcb_match;
            end
        end else if (!done && cnt_q != 2'd0) begin
            cnt_q <= cnt_q - 2'd1;
        end
    end

    always_comb begin
        sel_n    = '1;
        wait_cnt = 2'd0;
        rdy_use  = 1'b0;
        pcb_hit  = 1'b0;
        cyc_done = done;
        unique case (state)
            ST_IDLE: ;
            ST_BUSY: begin
                sel_n    = ~sel_q;
                wait_cnt = waits_q;
                rdy_use  = ru_q;
                pcb_hit  = pcb_q;
            end
        endcase
    end

    assert_idle_no_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cyc_start) |=> (sel_n == '1));
    assert_done_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (sel_n == '1));
    assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !cyc_done) |=> $stable(sel_n));
    assert_ready_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && rdy_use) |-> rdy);
    assert_pcb_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pcb_hit |-> (sel_n == '1 && !rdy_use && cyc_done));
    assert_inta_not_pcb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cyc_start && inta) |=> (!pcb_hit && rdy_use && sel_n == '1));
    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !cyc_done && cyc_start) |=> $stable(wait_cnt));
endmodule

// File: rtl/csel_unit.sv
module csel_unit
    import csel_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int UMEM_RST_SIZE = 1024,
    parameter int PCB_RST_BASE  = 'h0FF00,
    parameter int PCB_SIZE      = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [2*ADDR_W+3:0]   cfg_wdata,
    input  logic                  cyc_start,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  is_mem,
    input  logic                  inta,
    input  logic                  rdy,
    output logic [NUM_RG-1:0]     sel_n,
    output logic [1:0]            wait_cnt,
    output logic                  rdy_use,
    output logic                  pcb_hit,
    output logic                  cyc_done
);
    logic [NUM_RG-1:0][ADDR_W-1:0] rg_base, rg_size;
    region_ctl_t [NUM_RG-1:0]      rg_ctl;
    logic [ADDR_W-1:0]             pcb_base;
    logic                          pcb_in_mem;
    logic [NUM_RG-1:0]             hit_vec;
    logic                          pcb_match, win_rdy;
    logic [1:0]                    win_waits;

    csel_cfg_regs #(
        .ADDR_W(ADDR_W), .UMEM_RST_SIZE(UMEM_RST_SIZE), .PCB_RST_BASE(PCB_RST_BASE)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rg_base(rg_base), .rg_size(rg_size),
        .rg_ctl(rg_ctl), .pcb_base(pcb_base), .pcb_in_mem(pcb_in_mem)
    );

    csel_decode #(.ADDR_W(ADDR_W), .PCB_SIZE(PCB_SIZE)) dec_i (
        .addr(addr), .is_mem(is_mem), .inta(inta), .rg_base(rg_base),
        .rg_size(rg_size), .rg_ctl(rg_ctl), .pcb_base(pcb_base),
        .pcb_in_mem(pcb_in_mem), .hit_vec(hit_vec), .pcb_match(pcb_match),
        .win_waits(win_waits), .win_rdy(win_rdy)
    );

    csel_cycle_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .inta(inta), .rdy(rdy),
        .hit_vec(hit_vec), .pcb_match(pcb_match), .win_waits(win_waits),
        .win_rdy(win_rdy), .sel_n(sel_n), .wait_cnt(wait_cnt), .rdy_use(rdy_use),
        .pcb_hit(pcb_hit), .cyc_done(cyc_done)
    );
endmodule

// File: tb/csel_unit_tb.sv
`timescale 1ns/1ps
module csel_unit_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [2*AW+3:0] cfg_wdata = '0;
    logic          cyc_start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          is_mem = 1'b0;
    logic          inta = 1'b0;
    logic          rdy = 1'b0;
    logic [3:0]    sel_n;
    logic [1:0]    wait_cnt;
    logic          rdy_use, pcb_hit, cyc_done;

    always #2.5 clk = ~clk;

    csel_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .addr(addr), .is_mem(is_mem),
        .inta(inta), .rdy(rdy), .sel_n(sel_n), .wait_cnt(wait_cnt),
        .rdy_use(rdy_use), .pcb_hit(pcb_hit), .cyc_done(cyc_done)
    );

    int    nchk = 0, nfail = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_base[4], m_size[4], m_w[4];
    bit m_en[4], m_re[4];
    int m_pb;
    bit m_pm;
    bit m_act, m_ru, m_pcb;
    bit [3:0] m_sel;
    int m_cnt, m_wt;

    function automatic bit m_done();
        return m_act && m_cnt == 0 && (!m_ru || rdy);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_base[i] = 0; m_size[i] = 0; m_w[i] = 0; m_en[i] = 0; m_re[i] = 0;
            end
            m_base[0] = 'hFFC00; m_size[0] = 1024; m_w[0] = 3; m_en[0] = 1; m_re[0] = 1;
            m_pb = 'hFF00; m_pm = 0;
            m_act = 0; m_ru = 0; m_pcb = 0; m_sel = 0; m_cnt = 0; m_wt = 0;
        end else begin
            if (!m_act) begin
                if (cyc_start) begin
                    bit [3:0] h;
                    int a;
                    a = int'(addr);
                    for (int i = 0; i < 4; i++)
                        h[i] = m_en[i] && ((i == 3) ? !is_mem : is_mem) &&
                               a >= m_base[i] && a < m_base[i] + m_size[i];
                    m_pcb = !inta && (is_mem == m_pm) && a >= m_pb && a < m_pb + 256;
                    if (m_pcb || inta) begin
                        m_sel = 0; m_wt = 0; m_ru = inta;
                    end else begin
                        m_sel = h; m_wt = 0; m_ru = 0;
                        if (h[3]) begin m_wt = m_w[3]; m_ru = m_re[3]; end
                        if (h[1]) begin m_wt = m_w[1]; m_ru = m_re[1]; end
                        if (h[0]) begin m_wt = m_w[0]; m_ru = m_re[0]; end
                        if (h[2]) begin m_wt = m_w[2]; m_ru = m_re[2]; end
                    end
                    m_cnt = m_wt;
                    m_act = 1;
                end
            end else if (m_done()) begin
                m_act = 0;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
            if (cfg_we) begin
                if (cfg_addr < 4) begin
                    m_base[cfg_addr] = int'(cfg_wdata[19:0]);
                    m_size[cfg_addr] = int'(cfg_wdata[39:20]);
                    m_w[cfg_addr]    = int'(cfg_wdata[41:40]);
                    m_re[cfg_addr]   = cfg_wdata[42];
                    m_en[cfg_addr]   = cfg_wdata[43];
                end else if (cfg_addr == 4) begin
                    m_pb = int'(cfg_wdata[19:0]);
                    m_pm = cfg_wdata[20];
                end
            end
        end
    end

    // per-clock comparison, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(sel_n == (m_act ? ~m_sel : 4'hF), {cur_req, " sel_n"}, int'(sel_n), int'(m_act ? ~m_sel : 4'hF));
            chk(wait_cnt == (m_act ? 2'(m_wt) : 2'd0), {cur_req, " wait_cnt"}, int'(wait_cnt), m_act ? m_wt : 0);
            chk(rdy_use == (m_act && m_ru), {cur_req, " rdy_use"}, int'(rdy_use), int'(m_act && m_ru));
            chk(pcb_hit == (m_act && m_pcb), {cur_req, " pcb_hit"}, int'(pcb_hit), int'(m_act && m_pcb));
            chk(cyc_done == m_done(), {cur_req, " cyc_done"}, int'(cyc_done), int'(m_done()));
        end
    end

    task automatic cfg_region(input int idx, input bit en, input bit re, input int w,
                              input int base, input int size);
        cfg_we = 1; cfg_addr = 3'(idx);
        cfg_wdata = {en, re, 2'(w), 20'(size), 20'(base)};
        @(negedge clk);
        cfg_we = 0;
        @(negedge clk);
    endtask

    task automatic cfg_reloc(input bit mem, input int base);
        cfg_we = 1; cfg_addr = 3'd4;
        cfg_wdata = '0;
        cfg_wdata[20:0] = {mem, 20'(base)};
        @(negedge clk);
        cfg_we = 0;
        @(negedge clk);
    endtask

    // runs one bus cycle; rdy is high from ST_BUSY clock lat+1 onward
    task automatic bus_cycle(input int a, input bit mem, input bit ia, input int lat,
                             input int exp_len, input string tag, input bit restart);
        int k;
        cur_req = tag;
        addr = 20'(a); is_mem = mem; inta = ia; cyc_start = 1; rdy = (lat == 0);
        @(negedge clk);
        k = 1;
        forever begin
            rdy = (k > lat);
            if (restart && k == 1) begin
                cyc_start = 1; addr = 20'(a ^ 'h55);
            end else begin
                cyc_start = 0;
            end
            #1;
            if (cyc_done || k > 40) break;
            @(negedge clk);
            k++;
        end
        chk(k == exp_len, {tag, " cycle length"}, k, exp_len);
        @(negedge clk);
        cyc_start = 0; rdy = 0; inta = 0;
        addr = 20'(a);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sel_n == 4'hF, "R1 reset sel_n", int'(sel_n), 'hF);
        chk(cyc_done == 0, "R1 reset done", int'(cyc_done), 0);
        rst_n = 1;
        @(negedge clk);
        bus_cycle('hFFFF0, 1, 0, 0, 4, "R1", 0);
        bus_cycle('h00100, 1, 0, 0, 1, "R1", 0);
        // R11 / R3 lower region
        cfg_region(1, 1, 0, 1, 'h0, 'h4000);
        bus_cycle('h00100, 1, 0, 0, 2, "R11", 0);
        bus_cycle('h00100, 0, 0, 0, 1, "R3", 0);
        // R6 peripheral region with ready
        cfg_region(3, 1, 1, 2, 'h0400, 'h100);
        bus_cycle('h00410, 0, 0, 5, 6, "R6", 0);
        bus_cycle('h00410, 0, 0, 0, 3, "R6", 0);
        bus_cycle('h00410, 1, 0, 0, 2, "R3", 0);
        // R4 / R5 overlap, mid wins with 3 waits and ready ignored
        cfg_region(2, 1, 0, 3, 'h2000, 'h1000);
        bus_cycle('h02100, 1, 0, 10, 4, "R4", 0);
        bus_cycle('h02FFF, 1, 0, 0, 4, "R5", 0);
        bus_cycle('h03000, 1, 0, 0, 2, "R3", 0);
        // R7 window hit overlapping a peripheral region
        cfg_region(3, 1, 1, 3, 'hFF00, 'h100);
        bus_cycle('h0FF10, 0, 0, 8, 1, "R7", 0);
        // R8 relocate to I/O 0, R9 interrupt acknowledge at 0
        cfg_reloc(0, 'h0);
        bus_cycle('h00010, 0, 0, 5, 1, "R8", 0);
        bus_cycle('h00000, 0, 1, 3, 4, "R9", 0);
        // R8 move to memory over lower and mid regions
        cfg_reloc(1, 'h2800);
        bus_cycle('h02810, 1, 0, 0, 1, "R8", 0);
        bus_cycle('h00010, 0, 0, 0, 1, "R8", 0);
        bus_cycle('h028FF, 1, 0, 0, 1, "R7", 0);
        bus_cycle('h02900, 1, 0, 0, 4, "R8", 0);
        // R10 start strobe while busy
        bus_cycle('h02100, 1, 0, 0, 4, "R10", 1);
        // R2 selects idle afterwards
        chk(sel_n == 4'hF, "R2 idle sel_n", int'(sel_n), 'hF);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule